// File: doc/BRIEF.md
# Sparse Bitmap Set-Bit Scanner

The scanner walks a large bitmap that sits in a word-organised synchronous memory and returns the index of every set bit as a stream, lowest index first. A scan begins with a start pulse. The scanner then reads the bitmap one 32-bit word at a time through a read port with one cycle of latency.

Within a word, the lowest remaining set bit is isolated by ANDing the word with its two's-complement negation. That one-hot value is turned into a 5-bit offset by OR-reducing it under fixed alternating masks. The bit is then removed from the working word. A word that is zero, or has just been emptied, is passed over in the same cycle, and the read for the following word is issued at once. A done flag rises after the last word has been examined.

A typical user is a block-processing pipeline that only needs to visit the few marked tiles of an image. Such a user can spend one cycle per marked tile rather than one cycle per tile.

Top module: `bitmap_scanner`

## Requirements
- R1: Reported positions rise strictly within one scan. Each position is 16 bits: the word address in bits 15:5 and the bit offset inside the word in bits 4:0.
- R2: Every set bit of the map is reported exactly once per scan, and no clear bit is reported.
- R3: With the output always ready, each word costs exactly max(1, number of set bits in it) cycles. The done flag goes high exactly that many clock edges, summed over all words, after the edge that samples the start pulse.
- R4: An all-zero map produces no output, and done rises 2048 edges after the start edge.
- R5: While a position is offered and ready is low, the offered position stays valid and unchanged on the next cycle.
- R6: Word reads go out in ascending address order. Every read of a nonzero address is exactly one above the previous read address.
- R7: Done stays high until a new start pulse. A start pulse during a running scan is ignored: it changes neither the output sequence nor the scan length.
- R8: A start pulse while done is high clears done on the next cycle and rescans the map from word 0.
- R9: After reset, done, output valid and the memory read strobe are all low. No position is offered while done is high.
- R10: The lowest and highest map positions (0 and 65535) are reported. A word with all 32 bits set yields 32 positions in 32 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; honoured only when no scan is running |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 11 | Memory word address |
| mem_data_i | input | 32 | Read data, valid one cycle after the strobe |
| pos_valid_o | output | 1 | A position is offered |
| pos_ready_i | input | 1 | Consumer accepts the offered position |
| pos_o | output | 16 | Bit position: word address and offset |
| done_o | output | 1 | Scan complete |

## Verification
The bench targets several corner cases, each tied to a fault it would expose:

- **All-zero map.** A scanner that stalls on empty words, or that does not flag the last one, shows up as a cycle count other than 2048 or as a scan that never finishes.
- **Map edges and a fully set word.** Bit 0, bit 65535 and a fully set word catch an encoder with a wrong mask or an off-by-one word address, which would report wrong positions. A broken clear step would repeat or skip bits.
- **Random back-pressure.** This targets a scanner that advances on valid alone, which drops positions or changes the offered one while ready is low.
- **Start pulses.** A pulse in mid-scan and a restart after done would expose a controller that restarts, or that fails to restart, as a changed cycle count or as a missing second sequence.

// File: rtl/bms_pkg.sv
package bms_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE = 2'd0,
    SCAN_RUN  = 2'd1,
    SCAN_DONE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/bms_lowbit.sv
// Lowest-set-bit isolation and removal.
module bms_lowbit #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] onehot_o,
  output logic [WORD_W-1:0] rest_o,
  output logic              empty_o
);
  logic [WORD_W-1:0] neg_word;

  assign neg_word = (~word_i) + WORD_W'(1);
  assign onehot_o = word_i & neg_word;
  assign rest_o   = word_i & ~onehot_o;
  assign empty_o  = (word_i == '0);
endmodule

// File: rtl/bms_encode.sv
// One-hot to index: index bit k is the OR of the one-hot bits whose index has bit k set.
module bms_encode #(
  parameter int WORD_W = 32,
  localparam int OFS_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] onehot_i,
  output logic [OFS_W-1:0]  index_o
);
  for (genvar k = 0; k < OFS_W; k++) begin : g_bit
    logic [WORD_W-1:0] mask;
    always_comb begin
      for (int i = 0; i < WORD_W; i++) begin
        mask[i] = ((i >> k) & 1) == 1;
      end
    end
    assign index_o[k] = |(onehot_i & mask);
  end
endmodule

// File: rtl/bms_word_reg.sv
// Holds the partially consumed word; selects fresh memory data when nothing is held.
module bms_word_reg #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              fresh_vld_i,
  input  logic [WORD_W-1:0] fresh_word_i,
  input  logic [ADDR_W-1:0] fresh_addr_i,
  input  logic              retire_i,
  input  logic              take_i,
  input  logic [WORD_W-1:0] rest_i,
  output logic              cur_ok_o,
  output logic [WORD_W-1:0] cur_word_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic              held_vld_q;
  logic [WORD_W-1:0] held_word_q;
  logic [ADDR_W-1:0] held_addr_q;

  assign cur_ok_o   = held_vld_q | fresh_vld_i;
  assign cur_word_o = held_vld_q ? held_word_q : fresh_word_i;
  assign cur_addr_o = held_vld_q ? held_addr_q : fresh_addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_vld_q  <= 1'b0;
      held_word_q <= '0;
      held_addr_q <= '0;
    end else if (clear_i || retire_i) begin
      held_vld_q <= 1'b0;
    end else if (cur_ok_o) begin
      held_vld_q  <= 1'b1;
      held_word_q <= take_i ? rest_i : cur_word_o;
      held_addr_q <= cur_addr_o;
    end
  end
endmodule

// File: rtl/bms_ctrl.sv
// Scan state and word fetch sequencing.
module bms_ctrl
  import bms_pkg::*;
#(
  parameter int NUM_WORDS = 2048,
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              retire_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic              running_o,
  output logic              start_go_o,
  output logic              fresh_vld_o,
  output logic [ADDR_W-1:0] fresh_addr_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  scan_state_e state_q, state_d;
  logic        last_word;
  logic        finish;

  assign running_o   = (state_q == SCAN_RUN);
  assign start_go_o  = start_i && !running_o;
  assign last_word   = (cur_addr_i == LAST_ADDR);
  assign finish      = running_o && retire_i && last_word;
  assign done_o      = (state_q == SCAN_DONE);

  // Next word is requested in the cycle the current one retires: no bubble.
  assign mem_rd_o   = start_go_o || (running_o && retire_i && !last_word);
  assign mem_addr_o = start_go_o ? '0 : cur_addr_i + ADDR_W'(1);

  always_comb begin
    state_d = state_q;
    if (start_go_o)  state_d = SCAN_RUN;
    else if (finish) state_d = SCAN_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= SCAN_IDLE;
      fresh_vld_o  <= 1'b0;
      fresh_addr_o <= '0;
    end else begin
      state_q     <= state_d;
      fresh_vld_o <= mem_rd_o;
      if (mem_rd_o) fresh_addr_o <= mem_addr_o;
    end
  end
endmodule

// File: rtl/bitmap_scanner.sv
module bitmap_scanner #(
  parameter int WORD_W   = 32,
  parameter int MAP_BITS = 65536,
  localparam int NUM_WORDS = MAP_BITS / WORD_W,
  localparam int ADDR_W    = $clog2(NUM_WORDS),
  localparam int OFS_W     = $clog2(WORD_W),
  localparam int POS_W     = ADDR_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              pos_valid_o,
  input  logic              pos_ready_i,
  output logic [POS_W-1:0]  pos_o,
  output logic              done_o
);
  logic              running, start_go;
  logic              fresh_vld;
  logic [ADDR_W-1:0] fresh_addr;
  logic              cur_ok;
  logic [WORD_W-1:0] cur_word, onehot, rest;
  logic [ADDR_W-1:0] cur_addr;
  logic              empty;
  logic [OFS_W-1:0]  ofs;
  logic              take, retire;

  assign pos_valid_o = running && cur_ok && !empty;
  assign take        = pos_valid_o && pos_ready_i;
  assign retire      = running && cur_ok && (empty || (take && rest == '0));
  assign pos_o       = {cur_addr, ofs};

  bms_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .retire_i    (retire),
    .cur_addr_i  (cur_addr),
    .running_o   (running),
    .start_go_o  (start_go),
    .fresh_vld_o (fresh_vld),
    .fresh_addr_o(fresh_addr),
    .mem_rd_o    (mem_rd_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (done_o)
  );

  bms_word_reg #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_word (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_go),
    .fresh_vld_i (fresh_vld),
    .fresh_word_i(mem_data_i),
    .fresh_addr_i(fresh_addr),
    .retire_i    (retire),
    .take_i      (take),
    .rest_i      (rest),
    .cur_ok_o    (cur_ok),
    .cur_word_o  (cur_word),
    .cur_addr_o  (cur_addr)
  );

  bms_lowbit #(.WORD_W(WORD_W)) u_lowbit (
    .word_i  (cur_word),
    .onehot_o(onehot),
    .rest_o  (rest),
    .empty_o (empty)
  );

  bms_encode #(.WORD_W(WORD_W)) u_encode (
    .onehot_i(onehot),
    .index_o (ofs)
  );
endmodule

// File: rtl/bitmap_scanner_chk.sv
module bitmap_scanner_chk #(
  parameter int ADDR_W = 11,
  parameter int POS_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_rd_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              pos_valid_o,
  input logic              pos_ready_i,
  input logic [POS_W-1:0]  pos_o,
  input logic              done_o
);
  logic              seen_q;
  logic [POS_W-1:0]  last_pos_q;
  logic              rd_seen_q;
  logic [ADDR_W-1:0] last_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q     <= 1'b0;
      last_pos_q <= '0;
      rd_seen_q  <= 1'b0;
      last_rd_q  <= '0;
    end else begin
      if (mem_rd_o && mem_addr_o == '0) seen_q <= 1'b0;
      else if (pos_valid_o && pos_ready_i) begin
        seen_q     <= 1'b1;
        last_pos_q <= pos_o;
      end
      if (mem_rd_o) begin
        rd_seen_q <= 1'b1;
        last_rd_q <= mem_addr_o;
      end
    end
  end

  // R1
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_valid_o && pos_ready_i && seen_q |-> pos_o > last_pos_q);
  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_valid_o && !pos_ready_i |=> pos_valid_o && $stable(pos_o));
  // R6
  rd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mem_addr_o != '0 |-> rd_seen_q && mem_addr_o == last_rd_q + ADDR_W'(1));
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o);
  // R8
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && start_i |=> !done_o);
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pos_valid_o);
endmodule

bind bitmap_scanner bitmap_scanner_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .mem_rd_o   (mem_rd_o),
  .mem_addr_o (mem_addr_o),
  .pos_valid_o(pos_valid_o),
  .pos_ready_i(pos_ready_i),
  .pos_o      (pos_o),
  .done_o     (done_o)
);

// File: tb/bitmap_scanner_bench.sv
module bitmap_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mem_rd;
  logic [10:0] mem_addr;
  logic [31:0] mem_q = '0;
  logic        pos_valid;
  logic        pos_ready = 1'b1;
  logic [15:0] pos;
  logic        done;

  logic [31:0] map_mem [NWORDS];
  int          chk_cnt = 0;
  int          fail_cnt = 0;
  int          exp_q[$];
  string       cur_req = "R2";
  logic        rnd_ready = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_prev = 1'b0;
  logic [15:0] stall_pos = '0;
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitmap_scanner u_bitmap_scanner (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .mem_data_i (mem_q),
    .pos_valid_o(pos_valid),
    .pos_ready_i(pos_ready),
    .pos_o      (pos),
    .done_o     (done)
  );

  always @(posedge clk) if (mem_rd) mem_q <= map_mem[mem_addr];

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (rnd_ready) pos_ready <= lfsr[0] | lfsr[3];
    else           pos_ready <= 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard pop and stall stability.
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        check(pos_valid && pos == stall_pos, "R5", "held position", int'(pos), int'(stall_pos));
      end
      stall_prev = pos_valid && !pos_ready;
      stall_pos  = pos;
      if (pos_valid && pos_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected position", int'(pos), -1);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(int'(pos) == e, cur_req, "position", int'(pos), e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fail_cnt++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  task automatic clear_map();
    for (int w = 0; w < NWORDS; w++) map_mem[w] = '0;
  endtask

  task automatic set_bit(input int p);
    map_mem[p / 32][p % 32] = 1'b1;
  endtask

  // Driver: push expected positions, return expected scan length.
  task automatic push_expected(output int cost);
    cost = 0;
    for (int w = 0; w < NWORDS; w++) begin
      int n;
      n = 0;
      for (int b = 0; b < 32; b++) begin
        if (map_mem[w][b]) begin
          exp_q.push_back(w * 32 + b);
          n++;
        end
      end
      cost += (n == 0) ? 1 : n;
    end
  endtask

  task automatic run_scan(input string req, input bit poke_start, output int edges);
    @(posedge clk) start <= 1'b1;
    @(posedge clk) start <= 1'b0;
    edges = 0;
    forever begin
      @(negedge clk);
      if (done) break;
      @(posedge clk);
      edges++;
      if (poke_start && edges == 10) start <= 1'b1;
      if (poke_start && edges == 11) start <= 1'b0;
    end
    check(exp_q.size() == 0, req, "positions left unreported", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    int cost, edges;
    clear_map();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(!done, "R9", "done after reset", int'(done), 0);
    check(!pos_valid, "R9", "valid after reset", int'(pos_valid), 0);
    check(!mem_rd, "R9", "read strobe after reset", int'(mem_rd), 0);

    // R4 all-zero map
    cur_req = "R4";
    push_expected(cost);
    run_scan("R4", 1'b0, edges);
    check(edges == 2048, "R4", "empty map scan length", edges, 2048);
    check(done, "R7", "done held after scan", int'(done), 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(done, "R7", "done still held", int'(done), 1);

    // R10 / R1 sparse map with both extreme positions
    cur_req = "R10";
    clear_map();
    set_bit(0); set_bit(31); set_bit(32); set_bit(1000); set_bit(40000); set_bit(65535);
    push_expected(cost);
    run_scan("R10", 1'b0, edges);
    check(edges == cost, "R3", "sparse scan length", edges, cost);

    // R3 / R10 full word and split word
    cur_req = "R3";
    clear_map();
    map_mem[5] = 32'hFFFF_FFFF;
    map_mem[6] = 32'h8000_0001;
    map_mem[2047] = 32'h0001_0100;
    push_expected(cost);
    run_scan("R3", 1'b0, edges);
    check(edges == cost, "R3", "dense scan length", edges, cost);

    // R5 / R2 random back-pressure over a patterned map
    cur_req = "R2";
    clear_map();
    for (int w = 0; w < NWORDS; w += 37) map_mem[w] = 32'h1234_5678 ^ (w * 32'h9E37);
    map_mem[100] = 32'hFFFF_FFFF;
    push_expected(cost);
    rnd_ready = 1'b1;
    run_scan("R2", 1'b0, edges);
    rnd_ready = 1'b0;
    repeat (2) @(posedge clk);

    // R7 start during a running scan is ignored
    cur_req = "R7";
    clear_map();
    set_bit(3); set_bit(9); set_bit(700); set_bit(65534);
    push_expected(cost);
    run_scan("R7", 1'b1, edges);
    check(edges == cost, "R7", "scan length with mid-scan start", edges, cost);

    // R8 restart after done rescans the same map
    cur_req = "R8";
    push_expected(cost);
    run_scan("R8", 1'b0, edges);
    check(edges == cost, "R8", "rescan length", edges, cost);

    $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
    $finish;
  end
endmodule